// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive monitor for controller testbenches that drive an asynchronous EDO DRAM. A fast clock samples the active-low row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe, all assumed already synchronous to that clock. From the order in which strobe edges arrive, the monitor decides what kind of memory cycle each row-strobe period was. When the row strobe returns high, it emits a one-cycle event that carries a type code and a byte-lane mask.

The cycle type comes from the OR of the two column strobes: the first access window opens when either lane falls and closes when both are high again. Byte lanes are still followed one by one. A write lane is a lane whose column strobe is low while the write strobe is low, and a lane that falls after its window has opened is flagged as a staggered write. A second flag reports a row strobe that falls again too soon after it rose. Edge ordering is the only thing checked, counted in samples. Nanosecond timing values are not checked.

Top module: `dram_strobe_classifier`

## Requirements
- R1: While reset is asserted, and afterwards for as long as the row strobe stays high, evt_valid, evt_type, evt_lanes, stagger_err and precharge_err are all zero.
- R2: If a column strobe is low on the sample where the row strobe is first seen low, the event has type 6 (refresh with the column strobe first). Its lanes are the column strobes that were low on that sample, with bit 1 the upper lane and bit 0 the lower lane.
- R3: Such a refresh is reported as type 7 (self refresh) instead when the row strobe stays low for at least SELF_REFRESH_CYCLES samples after the sample where it fell.
- R4: If the row strobe falls with both column strobes high and neither column strobe goes low before it rises, the event has type 5 (row-only refresh) and lane mask 00.
- R5: If the write strobe is low on the first sample of the access window, the event has type 2 (early write). Its lanes are those whose column strobe was low on some window sample where the write strobe was also low.
- R6: If the write strobe falls on a later sample inside the window, and the output enable did not rise on an earlier window sample, the event has type 3 (delayed write). Lanes follow the rule in R5.
- R7: If the output enable rose (low to high) on a window sample after the first one and before the sample where the write strobe falls, the event has type 4 (read-modify-write). A rise on the same sample as the write fall still gives type 3.
- R8: A window with no write gives type 1 (read) when the output enable was low on any window sample, and type 0 (read with output disabled) otherwise. Its lanes are every lane that was low on any window sample.
- R9: stagger_err is high together with a write event (types 2 to 4) when either lane fell on a window sample after the first one. It is never high with any other type.
- R10: precharge_err pulses for one cycle, registered from the sample where the row strobe falls, when fewer than MIN_PRECHARGE high samples came before it since the previous rise. It never fires before the first rise after reset.
- R11: evt_valid pulses for exactly one cycle, registered from the first sample where the row strobe is high again. Only the first access window of a row period is classified, and strobe values on the rise sample itself are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_type | output | 3 | Cycle type code (0 to 7, see requirements) |
| evt_lanes | output | 2 | Lane mask, bit 1 upper, bit 0 lower |
| stagger_err | output | 1 | Staggered column strobes in a write |
| precharge_err | output | 1 | Row strobe high period was too short |

## Verification
The hardest cases are the ones that depend on state carried across row-strobe periods. The first is a hidden refresh: the column strobes stay low through a row rise and the next row fall, and that fall must become a refresh even though a read window was still open. The second is the precharge window, which must be hit exactly at MIN_PRECHARGE and one sample short of it. The stimulus builds each of these by holding the column strobes across the row edges and by setting the length of the high gap, and also drives coincident edges (output-enable rise on the write-fall sample, column and row strobes rising together, a second page access) to pin down which sample decides each case.

// File: rtl/dram_strobe_classifier.sv
module dram_strobe_classifier #(
  parameter int MIN_PRECHARGE       = 3,
  parameter int SELF_REFRESH_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       ucas_n,
  input  logic       lcas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       evt_valid,
  output logic [2:0] evt_type,
  output logic [1:0] evt_lanes,
  output logic       stagger_err,
  output logic       precharge_err
);
  localparam int PW = $clog2(MIN_PRECHARGE + 1);
  localparam int HW = $clog2(SELF_REFRESH_CYCLES + 1);

  logic ras_q, ucas_q, lcas_q, we_q, oe_q;
  logic cbr, win_open, win_used, oe_lo, oe_rose, stag;
  logic [1:0] wkind, cbr_lanes, rd_lanes, wr_lanes;
  logic [PW-1:0] pre_cnt;
  logic [HW-1:0] hold_cnt;

  wire [1:0] lanes_now  = {~ucas_n, ~lcas_n};
  wire [1:0] lanes_prev = {~ucas_q, ~lcas_q};
  wire cas_now   = |lanes_now;
  wire fall      = ras_q & ~ras_n;
  wire rise      = ~ras_q & ras_n;
  wire active    = ~ras_q & ~ras_n;
  wire win_start = active & ~cbr & ~win_used & cas_now;
  wire win_cont  = active & win_open & cas_now;

  logic [2:0] nxt_type;
  logic [1:0] nxt_lanes;
  logic       nxt_stag;

  always_comb begin
    nxt_stag = 1'b0;
    if (cbr) begin
      nxt_type  = (hold_cnt == HW'(SELF_REFRESH_CYCLES)) ? 3'd7 : 3'd6;
      nxt_lanes = cbr_lanes;
    end else if (!win_used) begin
      nxt_type  = 3'd5;
      nxt_lanes = 2'b00;
    end else if (wkind != 2'd0) begin
      nxt_type  = 3'(wkind) + 3'd1;
      nxt_lanes = wr_lanes;
      nxt_stag  = stag;
    end else begin
      nxt_type  = oe_lo ? 3'd1 : 3'd0;
      nxt_lanes = rd_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ras_q, ucas_q, lcas_q, we_q, oe_q} <= '1;
      {cbr, win_open, win_used, oe_lo, oe_rose, stag} <= '0;
      wkind <= '0; cbr_lanes <= '0; rd_lanes <= '0; wr_lanes <= '0;
      pre_cnt <= PW'(MIN_PRECHARGE);
      hold_cnt <= '0;
      evt_valid <= 1'b0; evt_type <= '0; evt_lanes <= '0;
      stagger_err <= 1'b0; precharge_err <= 1'b0;
    end else begin
      {ras_q, ucas_q, lcas_q, we_q, oe_q} <= {ras_n, ucas_n, lcas_n, we_n, oe_n};
      evt_valid     <= rise;
      evt_type      <= rise ? nxt_type : 3'd0;
      evt_lanes     <= rise ? nxt_lanes : 2'b00;
      stagger_err   <= rise & nxt_stag;
      precharge_err <= fall & (pre_cnt < PW'(MIN_PRECHARGE));

      if (rise) pre_cnt <= PW'(1);
      else if (ras_n && pre_cnt < PW'(MIN_PRECHARGE)) pre_cnt <= pre_cnt + PW'(1);

      if (fall) begin
        cbr <= cas_now;
        cbr_lanes <= lanes_now;
        {win_open, win_used, oe_lo, oe_rose, stag} <= '0;
        wkind <= '0; rd_lanes <= '0; wr_lanes <= '0;
        hold_cnt <= '0;
      end else begin
        if (active && cbr && hold_cnt != HW'(SELF_REFRESH_CYCLES))
          hold_cnt <= hold_cnt + HW'(1);
        if (win_start) begin
          win_open <= 1'b1;
          win_used <= 1'b1;
          wkind    <= we_n ? 2'd0 : 2'd1;
          oe_lo    <= ~oe_n;
          rd_lanes <= lanes_now;
          wr_lanes <= we_n ? 2'b00 : lanes_now;
        end else if (win_cont) begin
          oe_lo    <= oe_lo | ~oe_n;
          oe_rose  <= oe_rose | (~oe_q & oe_n);
          if (wkind == 2'd0 && we_q && !we_n) wkind <= oe_rose ? 2'd3 : 2'd2;
          rd_lanes <= rd_lanes | lanes_now;
          wr_lanes <= wr_lanes | (we_n ? 2'b00 : lanes_now);
          stag     <= stag | (|(lanes_now & ~lanes_prev));
        end else if (active && win_open) begin
          win_open <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dram_strobe_classifier_chk.sv
module dram_strobe_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       evt_valid,
  input logic [2:0] evt_type,
  input logic [1:0] evt_lanes,
  input logic       stagger_err,
  input logic       precharge_err
);
  assert_evt_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);
  assert_evt_after_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ($past(ras_n) && !$past(ras_n, 2)));
  assert_stag_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stagger_err |-> (evt_valid && evt_type >= 3'd2 && evt_type <= 3'd4));
  assert_row_only_no_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type == 3'd5) |-> evt_lanes == 2'b00);
  assert_refresh_has_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_type >= 3'd6) |-> evt_lanes != 2'b00);
  assert_pre_err_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_err |-> (!$past(ras_n) && $past(ras_n, 2)));
  assert_quiet_without_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid |-> (evt_type == 3'd0 && evt_lanes == 2'b00 && !stagger_err));
endmodule

bind dram_strobe_classifier dram_strobe_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .evt_valid(evt_valid),
  .evt_type(evt_type), .evt_lanes(evt_lanes), .stagger_err(stagger_err),
  .precharge_err(precharge_err)
);

// File: tb/dram_strobe_classifier_test.sv
module dram_strobe_classifier_test;
  localparam int MINP = 3;
  localparam int SELFN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic evt_valid, stagger_err, precharge_err;
  logic [2:0] evt_type;
  logic [1:0] evt_lanes;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dram_strobe_classifier #(.MIN_PRECHARGE(MINP), .SELF_REFRESH_CYCLES(SELFN)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_lanes(evt_lanes), .stagger_err(stagger_err), .precharge_err(precharge_err));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: samples of one row period kept in a queue, analysed at the rise
  bit [3:0] q[$];
  bit [3:0] fs;
  bit prev_ras = 1'b1;
  int cyc = 0, rise_cyc = -1;

  function automatic bit low_any(bit [3:0] s); return !(s[3] && s[2]); endfunction
  function automatic bit [1:0] lanes(bit [3:0] s); return {~s[3], ~s[2]}; endfunction

  task automatic analyse(output int ty, output int ln, output int sg);
    int i, j, k, m, kind;
    bit oel;
    sg = 0;
    if (low_any(fs)) begin
      ty = (q.size() >= SELFN) ? 7 : 6; ln = lanes(fs); return;
    end
    i = -1;
    for (int t = 0; t < q.size(); t++) if (i < 0 && low_any(q[t])) i = t;
    if (i < 0) begin ty = 5; ln = 0; return; end
    j = q.size();
    for (int t = q.size() - 1; t > i; t--) if (!low_any(q[t])) j = t;
    kind = q[i][1] ? 0 : 1;
    for (k = i + 1; k < j && kind == 0; k++)
      if (q[k-1][1] && !q[k][1]) begin
        kind = 2;
        for (m = i + 1; m < k; m++) if (!q[m-1][0] && q[m][0]) kind = 3;
      end
    oel = 0; ln = 0;
    for (int t = i; t < j; t++) begin
      if (!q[t][0]) oel = 1;
      if (kind == 0) ln |= lanes(q[t]);
      else if (!q[t][1]) ln |= lanes(q[t]);
      if (t > i && ((lanes(q[t]) & ~lanes(q[t-1])) != 0)) sg = 1;
    end
    if (kind == 0) begin ty = oel ? 1 : 0; sg = 0; end
    else ty = kind + 1;
  endtask

  function automatic string tag_of(int ty);
    case (ty)
      0, 1: return "R8";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R4";
      6: return "R2";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    int ev, ty, ln, sg, pe;
    bit [3:0] s;
    ev = 0; ty = 0; ln = 0; sg = 0; pe = 0;
    s = {ucas_n, lcas_n, we_n, oe_n};
    if (!rst_n) begin
      prev_ras = 1; rise_cyc = -1; q.delete(); cyc = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        q.delete(); fs = s;
        pe = (rise_cyc >= 0 && (cyc - rise_cyc) < MINP) ? 1 : 0;
      end else if (!prev_ras && !ras_n) q.push_back(s);
      else if (!prev_ras && ras_n) begin
        analyse(ty, ln, sg); ev = 1; rise_cyc = cyc;
      end
      prev_ras = ras_n;
      cyc++;
    end
    #2;
    chk("R11 evt_valid", int'(evt_valid), ev);
    chk(ev ? tag_of(ty) : "R1 type", int'(evt_type), ty);
    chk(ev ? tag_of(ty) : "R1 lanes", int'(evt_lanes), ln);
    chk("R9 stagger_err", int'(stagger_err), sg);
    chk("R10 precharge_err", int'(precharge_err), pe);
  end

  task automatic drv(input bit r, u, l, w, o, input int n);
    @(negedge clk);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idle(); drv(1, 1, 1, 1, 1, 4); endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(evt_valid), 0);
    chk("R1 reset precharge", int'(precharge_err), 0);
    rst_n = 1'b1;
    idle();
    // R8 read, both lanes, output enabled
    drv(0,1,1,1,1,2); drv(0,0,0,1,0,3); drv(0,1,1,1,1,1); idle();
    // R8 read, upper lane, output disabled; column rises with row (R11 rise sample ignored)
    drv(0,1,1,1,1,1); drv(0,0,1,1,1,2); idle();
    // R5 early write, lower lane
    drv(0,1,1,1,1,1); drv(0,1,0,0,1,2); drv(0,1,1,1,1,1); idle();
    // R6 delayed write, both lanes
    drv(0,1,1,1,1,1); drv(0,0,0,1,1,2); drv(0,0,0,0,1,2); idle();
    // R7 read-modify-write
    drv(0,1,1,1,1,1); drv(0,0,0,1,0,2); drv(0,0,0,1,1,1); drv(0,0,0,0,1,2); idle();
    // R7 boundary: output-enable rise on the write-fall sample stays delayed write
    drv(0,1,1,1,1,1); drv(0,0,0,1,0,2); drv(0,0,0,0,1,2); idle();
    // R9 staggered write
    drv(0,1,1,1,1,1); drv(0,1,0,0,1,1); drv(0,0,0,0,1,2); idle();
    // R9 staggered read, no flag
    drv(0,1,1,1,1,1); drv(0,0,1,1,0,1); drv(0,0,0,1,0,2); idle();
    // R4 row-only refresh
    drv(0,1,1,1,1,3); idle();
    // R2 column-first refresh, lower lane
    drv(1,1,0,1,1,1); drv(0,1,0,1,1,3); idle();
    // R3 self refresh
    drv(1,0,0,1,1,1); drv(0,0,0,1,1,SELFN + 5); idle();
    // R2 hidden refresh: column held low across the row edges
    drv(0,1,1,1,1,1); drv(0,0,0,1,0,2); drv(1,0,0,1,0,MINP); drv(0,0,0,1,0,3); idle();
    // R10 precharge too short, then exactly at the limit
    drv(0,1,1,1,1,2); drv(1,1,1,1,1,MINP - 1); drv(0,1,1,1,1,2);
    drv(1,1,1,1,1,MINP); drv(0,1,1,1,1,2); idle();
    // R11 second page access ignored
    drv(0,1,1,1,1,1); drv(0,0,0,1,0,2); drv(0,1,1,1,1,1); drv(0,0,0,0,1,2);
    drv(0,1,1,1,1,1); idle();
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule